// File: doc/BRIEF.md
# Flash Instruction Line Buffer with Next-Line Prefetch

This block sits between a processor's instruction fetch port and a slow flash array. The flash array delivers one 128-bit line, which is 16 bytes of code, after a fixed number of wait cycles. The block keeps two such lines in buffers. A fetch that hits a buffered line returns its 16-bit or 32-bit instruction word in the same cycle. A fetch that misses stalls the core until the line has been read.

When prefetching is enabled, the block reads the line that follows the one being executed while the core works through the current line. A straight run of 16-bit fetches then runs without stalls. The cost of a branch depends on where its target lies. A target in a buffered line costs nothing. A target in the line being prefetched costs only the rest of that read. Any other target costs a full demand read, and the demand read aborts a prefetch that is heading elsewhere. A backward step into the line just before the current one marks a two-line loop. While such a loop runs, prefetching stops, so the loop's own lines stay resident.

The flash side is a plain address/enable port. The block holds the line index steady for the whole wait period and captures the data in the last cycle of that period.

Top module: `flash_fetch_buf`

## Requirements
- R1: Reset clears both line buffers and drops any read in progress. While reset is high, `ready` stays low, and the first fetch after reset always takes a full demand read.
- R2: A fetch that hits returns data in the same cycle as its request. The selected halfword is `addr[3:1]`. For a 16-bit fetch (`wide`=0), `rdata[15:0]` holds that halfword and `rdata[31:16]` is zero. For a 32-bit fetch, `rdata` is {next halfword, addressed halfword}.
- R3: A miss with the flash side idle gives `ready` exactly WAIT_CYC+2 cycles after the request first appears. During the read, `fl_addr` holds for WAIT_CYC+1 cycles with `fl_en` high, and the data is captured in the last of those cycles.
- R4: A 32-bit fetch at halfword index 7 needs both its line and the following line. It completes only when both are buffered, so from a cold state it costs two demand reads, which is 2*(WAIT_CYC+2) stall cycles.
- R5: With `pf_en`=1, sequential 16-bit fetches over many lines stall only on the first line.
- R6: With `pf_en`=0, no flash read starts without a missing fetch, and each new line in a sequential run stalls WAIT_CYC+2 cycles.
- R7: A fetch that misses on the line being prefetched waits only for the remaining cycles of that read. A request made in the first cycle of the prefetch stalls WAIT_CYC+1 cycles.
- R8: A miss on a line other than the one being prefetched aborts the prefetch at once and stalls exactly WAIT_CYC+2 cycles.
- R9: A demand read replaces the buffer that was used least recently by a completed fetch.
- R10: A loop over two consecutive lines, aligned to a 16-byte boundary, runs with no stall from its third pass on while prefetching is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pf_en | input | 1 | Enables next-line prefetch |
| req | input | 1 | Fetch request, held until `ready` |
| addr | input | AW | Fetch byte address, halfword aligned |
| wide | input | 1 | 1 selects a 32-bit fetch, 0 a 16-bit fetch |
| rdata | output | 32 | Instruction data, valid when `ready` is high |
| ready | output | 1 | Fetch completes this cycle |
| fl_en | output | 1 | Flash read in progress |
| fl_addr | output | AW-4 | Line index presented to the flash |
| fl_data | input | 128 | Line data from the flash |

## Verification
A stale or wrongly tagged buffer shows up at once on `rdata`, in the same cycle as the hit that reads it. Every fetch in the sweeps is compared with an arithmetic pattern tied to its halfword address. The flash model only returns real data after the line index has been steady for WAIT_CYC+1 cycles, so an early capture fills a buffer with a poison pattern. A wrong victim choice, a prefetch that is not aborted or a broken loop hold changes the stall count of one particular later fetch. The bench counts every stall cycle exactly, so it sees that change within a few fetches.

// File: rtl/ifb_pkg.sv
package ifb_pkg;

    localparam int NBUF      = 2;
    localparam int LINE_W    = 128;
    localparam int HW_W      = 16;
    localparam int HW_PER_LN = LINE_W / HW_W;
    localparam int HWI_W     = $clog2(HW_PER_LN);

    typedef logic [LINE_W-1:0] line_t;
    typedef logic [HW_W-1:0]   hword_t;
    typedef logic [HWI_W-1:0]  hw_idx_t;
    typedef logic              bsel_t;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_HIT,
        FS_WAIT,
        FS_DEMAND
    } fetch_state_e;

    typedef struct packed {
        logic  go;
        bsel_t sel;
    } fill_req_t;

    function automatic hword_t hw_pick(line_t ln, hw_idx_t i);
        return ln[i*HW_W +: HW_W];
    endfunction

endpackage

// File: rtl/ifb_linestore.sv
module ifb_linestore
    import ifb_pkg::*;
#(
    parameter int LIDX_W = 8,
    parameter int NQ     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  bsel_t             wr_sel,
    input  logic [LIDX_W-1:0] wr_line,
    input  line_t             wr_data,
    input  logic [LIDX_W-1:0] q_line [NQ],
    output logic [NQ-1:0]     q_hit,
    output logic [NQ-1:0]     q_sel,
    output line_t             rd_line [NBUF]
);

    logic              vld [NBUF];
    logic [LIDX_W-1:0] tag [NBUF];

    for (genvar b = 0; b < NBUF; b++) begin : g_buf
        logic              v_q;
        logic [LIDX_W-1:0] t_q;
        line_t             d_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
            end else if (wr_en && wr_sel == bsel_t'(b)) begin
                v_q <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en && wr_sel == bsel_t'(b)) begin
                t_q <= wr_line;
                d_q <= wr_data;
            end
        end

        assign vld[b]     = v_q;
        assign tag[b]     = t_q;
        assign rd_line[b] = d_q;
    end

    for (genvar q = 0; q < NQ; q++) begin : g_query
        logic h;
        logic s;
        always_comb begin
            h = 1'b0;
            s = 1'b0;
            for (int b = 0; b < NBUF; b++) begin
                if (vld[b] && tag[b] == q_line[q]) begin
                    h = 1'b1;
                    s = bsel_t'(b);
                end
            end
        end
        assign q_hit[q] = h;
        assign q_sel[q] = s;
    end

endmodule

// File: rtl/ifb_flash_seq.sv
module ifb_flash_seq
    import ifb_pkg::*;
#(
    parameter int LIDX_W   = 8,
    parameter int WAIT_CYC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  fill_req_t         start,
    input  logic [LIDX_W-1:0] start_line,
    output logic              busy,
    output logic [LIDX_W-1:0] line,
    output bsel_t             sel,
    output logic              done
);

    localparam int CW = $clog2(WAIT_CYC + 2);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
            line <= '0;
            sel  <= 1'b0;
        end else if (start.go) begin
            busy <= 1'b1;
            cnt  <= CW'(WAIT_CYC);
            line <= start_line;
            sel  <= start.sel;
        end else if (busy) begin
            if (cnt == '0) begin
                busy <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign done = busy && (cnt == '0);

endmodule

// File: rtl/flash_fetch_buf.sv
module flash_fetch_buf
    import ifb_pkg::*;
#(
    parameter int AW       = 12,
    parameter int WAIT_CYC = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pf_en,
    input  logic            req,
    input  logic [AW-1:0]   addr,
    input  logic            wide,
    output logic [31:0]     rdata,
    output logic            ready,
    output logic            fl_en,
    output logic [AW-5:0]   fl_addr,
    input  logic [127:0]    fl_data
);

    localparam int LIDX_W = AW - 4;
    localparam int NQ     = 4;
    localparam int Q_LO   = 0;
    localparam int Q_HI   = 1;
    localparam int Q_CUR  = 2;
    localparam int Q_NXT  = 3;

    typedef logic [LIDX_W-1:0] lidx_t;

    // fetch decode
    lidx_t   lo_line, hi_line, fetched_line, miss_line;
    hw_idx_t hw_i;
    logic    straddle;

    assign lo_line  = addr[AW-1:4];
    assign hi_line  = lo_line + 1'b1;
    assign hw_i     = addr[3:1];
    assign straddle = wide && (hw_i == hw_idx_t'(HW_PER_LN - 1));

    // line store
    lidx_t        q_line [NQ];
    logic [NQ-1:0] q_hit, q_sel;
    line_t        buf_data [NBUF];

    // read sequencer
    fill_req_t start;
    lidx_t     start_line;
    logic      seq_busy, seq_done;
    lidx_t     seq_line;
    bsel_t     seq_sel;

    // tracking state
    lidx_t cur_line, nxt_cur, loop_base, nxt_base;
    logic  cur_v, nxt_cur_v, hold, nxt_hold;
    bsel_t lru;

    fetch_state_e fst;
    logic         have_all, miss;
    bsel_t        dem_sel, pf_sel, fetched_sel;
    logic         pf_go;

    assign q_line[Q_LO]  = lo_line;
    assign q_line[Q_HI]  = hi_line;
    assign q_line[Q_CUR] = nxt_cur;
    assign q_line[Q_NXT] = nxt_cur + 1'b1;

    ifb_linestore #(.LIDX_W(LIDX_W), .NQ(NQ)) store_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (seq_done),
        .wr_sel  (seq_sel),
        .wr_line (seq_line),
        .wr_data (fl_data),
        .q_line  (q_line),
        .q_hit   (q_hit),
        .q_sel   (q_sel),
        .rd_line (buf_data)
    );

    ifb_flash_seq #(.LIDX_W(LIDX_W), .WAIT_CYC(WAIT_CYC)) seq_i (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_line (start_line),
        .busy       (seq_busy),
        .line       (seq_line),
        .sel        (seq_sel),
        .done       (seq_done)
    );

    // hit and miss classification
    assign have_all  = q_hit[Q_LO] && (!straddle || q_hit[Q_HI]);
    assign miss_line = q_hit[Q_LO] ? hi_line : lo_line;

    always_comb begin
        if (!req) begin
            fst = FS_IDLE;
        end else if (have_all) begin
            fst = FS_HIT;
        end else if (seq_busy && seq_line == miss_line) begin
            fst = FS_WAIT;
        end else begin
            fst = FS_DEMAND;
        end
    end

    assign ready = (fst == FS_HIT);
    assign miss  = (fst == FS_WAIT) || (fst == FS_DEMAND);

    // data steering
    line_t  lo_data, hi_data;
    hword_t h0, h1;

    assign lo_data = buf_data[q_sel[Q_LO]];
    assign hi_data = buf_data[q_sel[Q_HI]];
    assign h0      = hw_pick(lo_data, hw_i);
    assign h1      = (hw_i == hw_idx_t'(HW_PER_LN - 1)) ? hw_pick(hi_data, '0)
                                                       : hw_pick(lo_data, hw_i + 1'b1);
    assign rdata   = !ready ? 32'h0 : (wide ? {h1, h0} : {16'h0, h0});

    // victim selection: never evict a line the pending fetch still needs
    always_comb begin
        if (q_hit[Q_LO]) begin
            dem_sel = ~q_sel[Q_LO];
        end else if (straddle && q_hit[Q_HI]) begin
            dem_sel = ~q_sel[Q_HI];
        end else begin
            dem_sel = lru;
        end
    end

    assign fetched_line = straddle ? hi_line : lo_line;
    assign fetched_sel  = straddle ? q_sel[Q_HI] : q_sel[Q_LO];
    assign nxt_cur      = ready ? fetched_line : cur_line;
    assign nxt_cur_v    = ready || cur_v;
    assign pf_sel       = q_hit[Q_CUR] ? ~q_sel[Q_CUR] : lru;

    // two-line loop detection
    always_comb begin
        nxt_hold = hold;
        nxt_base = loop_base;
        if (ready) begin
            if (cur_v && fetched_line == cur_line - 1'b1) begin
                nxt_hold = 1'b1;
                nxt_base = fetched_line;
            end else if (!(fetched_line == loop_base || fetched_line == loop_base + 1'b1)) begin
                nxt_hold = 1'b0;
            end
        end
    end

    assign pf_go = pf_en && nxt_cur_v && !nxt_hold && !seq_busy && !miss && !q_hit[Q_NXT];

    always_comb begin
        start = '{go: 1'b0, sel: 1'b0};
        start_line = nxt_cur + 1'b1;
        if (fst == FS_DEMAND) begin
            start = '{go: 1'b1, sel: dem_sel};
            start_line = miss_line;
        end else if (pf_go) begin
            start = '{go: 1'b1, sel: pf_sel};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_line  <= '0;
            cur_v     <= 1'b0;
            hold      <= 1'b0;
            loop_base <= '0;
            lru       <= 1'b0;
        end else begin
            cur_line  <= nxt_cur;
            cur_v     <= nxt_cur_v;
            hold      <= nxt_hold;
            loop_base <= nxt_base;
            if (ready) begin
                lru <= ~fetched_sel;
            end
        end
    end

    assign fl_en   = seq_busy;
    assign fl_addr = seq_line;

    logic unused_ok;
    assign unused_ok = ^{addr[0], q_sel[Q_NXT]};

endmodule

// File: rtl/flash_fetch_buf_chk.sv
module flash_fetch_buf_chk #(
    parameter int LIDX_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              pf_en,
    input logic              req,
    input logic              ready,
    input logic              fl_en,
    input logic [LIDX_W-1:0] fl_addr
);

    // R1
    reset_clears_chk: assert property (@(posedge clk) rst |=> (!fl_en && !ready));

    // R2
    ready_needs_req_chk: assert property (@(posedge clk) disable iff (rst) ready |-> req);

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fl_en && $past(fl_en) && !$past(req && !ready)) |-> $stable(fl_addr));

    // R6
    no_spec_read_chk: assert property (@(posedge clk) disable iff (rst)
        (!pf_en && !(req && !ready)) |=> !$rose(fl_en));

endmodule

bind flash_fetch_buf flash_fetch_buf_chk #(.LIDX_W(LIDX_W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .pf_en   (pf_en),
    .req     (req),
    .ready   (ready),
    .fl_en   (fl_en),
    .fl_addr (fl_addr)
);

// File: tb/flash_fetch_buf_tb.sv
module flash_fetch_buf_tb_top;

    localparam int AW   = 12;
    localparam int WAIT = 3;
    localparam int LW   = AW - 4;
    localparam int MISS = WAIT + 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pf_en = 1'b0;
    logic          req = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          wide = 1'b0;
    logic [31:0]   rdata;
    logic          ready;
    logic          fl_en;
    logic [LW-1:0] fl_addr;
    logic [127:0]  fl_data;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    flash_fetch_buf #(.AW(AW), .WAIT_CYC(WAIT)) dut_i (
        .clk(clk), .rst(rst), .pf_en(pf_en), .req(req), .addr(addr), .wide(wide),
        .rdata(rdata), .ready(ready), .fl_en(fl_en), .fl_addr(fl_addr), .fl_data(fl_data)
    );

    function automatic logic [15:0] hw_of(int g);
        return 16'(g * 3 + 5);
    endfunction

    // flash model: real data only once the line index has been steady WAIT+1 cycles
    int          run = 0;
    logic [LW-1:0] run_addr = '0;
    always @(posedge clk) begin
        if (!fl_en) begin
            run <= 0;
        end else if (fl_addr != run_addr) begin
            run <= 1;
        end else begin
            run <= run + 1;
        end
        run_addr <= fl_addr;
    end

    always_comb begin
        fl_data = {8{16'hFFFF}};
        if (fl_en && fl_addr == run_addr && run >= WAIT) begin
            for (int i = 0; i < 8; i++) fl_data[i*16 +: 16] = hw_of(int'(fl_addr) * 8 + i);
        end
    end

    task automatic check(string rq, bit ok, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1'b1;
        req = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    // issue one fetch starting now (just after an edge); returns stall cycles
    task automatic fetch(int a, bit w, output int st);
        int g;
        logic [31:0] exp;
        g = a >> 1;
        exp = w ? {hw_of(g + 1), hw_of(g)} : {16'h0, hw_of(g)};
        addr = AW'(a);
        wide = w;
        req = 1'b1;
        st = 0;
        forever begin
            @(negedge clk);
            if (ready) break;
            st++;
            if (st > 60) break;
            @(posedge clk); #1;
        end
        check("R2 data", rdata == exp, rdata, exp);
        @(posedge clk); #1;
    endtask

    task automatic idle();
        req = 1'b0;
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int st;
        int tot;

        // R1: ready stays low in reset, even with a request
        req = 1'b1;
        addr = '0;
        @(negedge clk);
        check("R1 ready in reset", ready == 1'b0, ready, 0);
        do_reset();

        // R3: cold miss latency, prefetch off
        pf_en = 1'b0;
        fetch(5 * 16, 0, st);
        check("R3 miss stall", st == MISS, st, MISS);

        // R2: all halfword offsets and both widths on buffered lines
        fetch(6 * 16, 0, st);
        fetch(7 * 16, 0, st);
        for (int h = 0; h < 8; h++) begin
            for (int w = 0; w < 2; w++) begin
                fetch(6 * 16 + h * 2, w[0], st);
                check("R2 hit no stall", st == 0, st, 0);
            end
        end

        // R4: straddling 32-bit fetch from cold needs two line reads
        fetch(9 * 16 + 14, 1, st);
        check("R4 straddle stall", st == 2 * MISS, st, 2 * MISS);

        // R1: reset invalidates buffered lines
        do_reset();
        fetch(6 * 16, 0, st);
        check("R1 invalidated", st == MISS, st, MISS);

        // R6: prefetch off, sequential stream stalls on every line
        for (int l = 32; l < 36; l++) begin
            for (int h = 0; h < 8; h++) begin
                fetch(l * 16 + h * 2, 0, st);
                check("R6 seq no pf", st == (h == 0 ? MISS : 0), st, h == 0 ? MISS : 0);
            end
        end

        // R5: prefetch on, stall only on the first line
        do_reset();
        pf_en = 1'b1;
        for (int l = 40; l < 48; l++) begin
            for (int h = 0; h < 8; h++) begin
                fetch(l * 16 + h * 2, 0, st);
                check("R5 seq pf", st == ((l == 40 && h == 0) ? MISS : 0), st,
                      (l == 40 && h == 0) ? MISS : 0);
            end
        end

        // R7: hit on the line being prefetched waits the remainder only
        do_reset();
        fetch(50 * 16, 0, st);
        fetch(51 * 16, 0, st);
        check("R7 partial wait", st == WAIT + 1, st, WAIT + 1);

        // R8: miss elsewhere aborts the prefetch
        do_reset();
        fetch(60 * 16, 0, st);
        fetch(100 * 16, 0, st);
        check("R8 abort pf", st == MISS, st, MISS);

        // R9: least recently used buffer is replaced
        do_reset();
        pf_en = 1'b0;
        fetch(70 * 16, 0, st);
        check("R9 A cold", st == MISS, st, MISS);
        fetch(80 * 16, 0, st);
        check("R9 B cold", st == MISS, st, MISS);
        fetch(70 * 16 + 4, 0, st);
        check("R9 A hit", st == 0, st, 0);
        fetch(90 * 16, 0, st);
        check("R9 C miss", st == MISS, st, MISS);
        fetch(70 * 16 + 8, 0, st);
        check("R9 A kept", st == 0, st, 0);
        fetch(80 * 16 + 2, 0, st);
        check("R9 B evicted", st == MISS, st, MISS);

        // R10: aligned two-line loop runs from buffers after warm-up
        do_reset();
        pf_en = 1'b1;
        for (int it = 0; it < 5; it++) begin
            tot = 0;
            for (int h = 0; h < 16; h++) begin
                fetch(16 * 16 + h * 2, 0, st);
                tot += st;
            end
            if (it >= 2) check("R10 loop resident", tot == 0, tot, 0);
            if (it == 0) check("R10 warm-up", tot == MISS, tot, MISS);
        end
        idle();

        summary();
        $finish;
    end

endmodule